// File: doc/BRIEF.md
# Status Flag Register with Interrupt Save and Restore

This block holds the processor's status flag word and keeps it consistent across three kinds of event: the start and end of an external block-transfer instruction, entry into an interrupt, and return from an interrupt. While a block transfer runs, a busy flag in the word is set. That flag drives an active-low pin towards the bus unit.

On interrupt entry the block shows the unchanged word on a push port, so the stack logic can save it. In the same edge it clears the five flags that an interrupt handler must not inherit and releases the bus pin. On return from interrupt the word is reloaded exactly from the popped copy, and the pin follows the restored busy flag.

Two guard flags must be clear before a block transfer may start inside a handler. The block raises a violation output when a transfer starts while either guard flag is set. A general write port updates the word. Its busy-flag field is ignored unless a transfer is already under way. The stack memory, the instruction decoder and the transfer engine sit outside this block.

Top module: `stat_word_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, stat_o is all zero, bus_busy_no is 1, push_word_o is zero and guard_viol_o is 0.
- R2: An accepted xfer_start_i sets the busy flag (bit 3) at the next edge. An accepted xfer_end_i without a start clears it. Start wins over end in the same cycle.
- R3: bus_busy_no is always the inverse of stat_o bit 3.
- R4: int_ack_i clears bits 0 (trace pending), 3 (busy), 4 (stack select), 5 (interrupt enable) and 6 (user mode) at the next edge. It keeps guard bits 1 and 2, and bus_busy_no goes high.
- R5: In a cycle with int_ack_i high, push_word_o equals stat_o before the edge. In every other cycle push_word_o is zero.
- R6: reti_i without int_ack_i loads bits 6..0 from reti_word_i and clears bits 15..7. bus_busy_no then follows the restored bit 3.
- R7: int_ack_i takes priority over xfer_start_i, reti_i and wr_en_i in the same cycle.
- R8: wr_en_i loads bits 6..0 except bit 3 from wr_word_i. While bit 3 is 0 the written bit 3 is ignored, and reserved bits 15..7 stay zero.
- R9: While bit 3 is 1 and no start or end arrives, wr_en_i also loads bit 3 from wr_word_i.
- R10: guard_viol_o is high in a cycle where an accepted xfer_start_i meets bit 1 or bit 2 set, and low otherwise.
- R11: reti_i takes priority over xfer_start_i, xfer_end_i and wr_en_i in the same cycle.

An event is accepted only when no higher-priority event (int_ack_i, then reti_i) is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_start_i | input | 1 | Block-transfer instruction begins |
| xfer_end_i | input | 1 | Block-transfer instruction ends |
| int_ack_i | input | 1 | Interrupt acknowledge strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| reti_word_i | input | W | Word popped from the interrupt stack |
| wr_en_i | input | 1 | General write enable |
| wr_word_i | input | W | General write data |
| stat_o | output | W | Current status word |
| push_word_o | output | W | Word to save on interrupt entry |
| bus_busy_no | output | 1 | Active-low bus-unit busy pin |
| guard_viol_o | output | 1 | Transfer started with a guard flag set |

## Verification
The assertions check five things on every cycle:
- the pin always mirrors the busy flag;
- acknowledge clears the five flags and releases the pin;
- a return reloads the exact popped word;
- an accepted start raises the busy flag;
- a write cannot raise the busy flag from idle.

The push-port contents, the guard violation output, the write behaviour while busy, and the full priority order among colliding strobes are shown only by the bench. The bench compares its behavioural model against every output on every cycle, across directed collisions and a pseudo-random strobe sequence.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int P_TPEND = 0;
  localparam int P_GRD_A = 1;
  localparam int P_GRD_B = 2;
  localparam int P_BUSY  = 3;
  localparam int P_STKS  = 4;
  localparam int P_IEN   = 5;
  localparam int P_USER  = 6;
  localparam int N_IMPL  = 7;

  localparam logic [N_IMPL-1:0] IMPL_BITS = 7'h7F;
  // flags dropped on interrupt entry: trace, busy, stack, enable, user
  localparam logic [N_IMPL-1:0] ACK_CLR_BITS = 7'h79;

  typedef struct packed {
    logic start;
    logic stop;
    logic ack;
    logic ret;
    logic wr;
  } stat_evt_t;
endpackage

// File: rtl/stat_next.sv
module stat_next #(
  parameter int W = 16
) (
  input  logic                cur_busy_i,
  input  logic [W-1:0]        cur_i,
  input  stat_pkg::stat_evt_t evt_i,
  input  logic [W-1:0]        reti_word_i,
  input  logic [W-1:0]        wr_word_i,
  output logic [W-1:0]        nxt_o
);
  import stat_pkg::*;
  localparam logic [W-1:0] IMPL_M = W'(IMPL_BITS);
  localparam logic [W-1:0] CLR_M  = W'(ACK_CLR_BITS);
  localparam logic [W-1:0] BUSY_M = W'(1) << P_BUSY;

  always_comb begin
    nxt_o = cur_i;
    if (evt_i.ack) begin
      nxt_o = cur_i & ~CLR_M;
    end else if (evt_i.ret) begin
      nxt_o = reti_word_i & IMPL_M;
    end else begin
      if (evt_i.wr) nxt_o = (wr_word_i & IMPL_M & ~BUSY_M) | (cur_i & BUSY_M);
      if (evt_i.start)                nxt_o[P_BUSY] = 1'b1;
      else if (evt_i.stop)            nxt_o[P_BUSY] = 1'b0;
      else if (evt_i.wr && cur_busy_i) nxt_o[P_BUSY] = wr_word_i[P_BUSY];
    end
  end
endmodule

// File: rtl/stat_reg.sv
module stat_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] nxt_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt_i;
  end
endmodule

// File: rtl/busy_pin.sv
module busy_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_nxt_i,
  output logic pin_no
);
  // separate flop so the pin is registered at the pad side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_no <= 1'b1;
    else         pin_no <= ~busy_nxt_i;
  end
endmodule

// File: rtl/stat_word_ctrl.sv
module stat_word_ctrl #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         xfer_start_i,
  input  logic         xfer_end_i,
  input  logic         int_ack_i,
  input  logic         reti_i,
  input  logic [W-1:0] reti_word_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_word_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] push_word_o,
  output logic         bus_busy_no,
  output logic         guard_viol_o
);
  import stat_pkg::*;
  localparam logic [W-1:0] IMPL_M = W'(IMPL_BITS);
  localparam logic [W-1:0] CLR_M  = W'(ACK_CLR_BITS);

  stat_evt_t    evt;
  logic [W-1:0] nxt;

  assign evt.start = xfer_start_i;
  assign evt.stop  = xfer_end_i;
  assign evt.ack   = int_ack_i;
  assign evt.ret   = reti_i;
  assign evt.wr    = wr_en_i;

  stat_next #(.W(W)) u_next (
    .cur_busy_i (stat_o[P_BUSY]),
    .cur_i      (stat_o),
    .evt_i      (evt),
    .reti_word_i(reti_word_i),
    .wr_word_i  (wr_word_i),
    .nxt_o      (nxt)
  );

  stat_reg #(.W(W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .nxt_i (nxt),
    .q_o   (stat_o)
  );

  busy_pin u_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_nxt_i(nxt[P_BUSY]),
    .pin_no    (bus_busy_no)
  );

  assign push_word_o  = int_ack_i ? stat_o : '0;
  assign guard_viol_o = xfer_start_i && !int_ack_i && !reti_i &&
                        (stat_o[P_GRD_A] || stat_o[P_GRD_B]);

  assert_pin_tracks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_no == !stat_o[P_BUSY]);

  assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i |=> ((stat_o & CLR_M) == '0) && bus_busy_no);

  assert_ack_keeps_guard_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i |=> (stat_o[P_GRD_A] == $past(stat_o[P_GRD_A])) &&
                  (stat_o[P_GRD_B] == $past(stat_o[P_GRD_B])));

  assert_reti_restore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !int_ack_i) |=> stat_o == ($past(reti_word_i) & IMPL_M));

  assert_start_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && !int_ack_i && !reti_i) |=> stat_o[P_BUSY] && !bus_busy_no);

  assert_wr_busy_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !stat_o[P_BUSY] && !xfer_start_i && !int_ack_i && !reti_i)
      |=> !stat_o[P_BUSY]);
endmodule

// File: tb/stat_word_ctrl_tb.sv
module stat_word_ctrl_tb;
  localparam int W = 16;
  localparam logic [15:0] IMPL = 16'h007F;
  localparam logic [15:0] CLRM = 16'h0079;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic xs = 0, xe = 0, ack = 0, ret = 0, we = 0;
  logic [W-1:0] rw = '0, ww = '0;
  logic [W-1:0] stat, push;
  logic busy_n, viol;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_stat = '0;
  bit done = 0;

  always #5 clk = ~clk;

  stat_word_ctrl #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_start_i(xs), .xfer_end_i(xe),
    .int_ack_i(ack), .reti_i(ret), .reti_word_i(rw), .wr_en_i(we),
    .wr_word_i(ww), .stat_o(stat), .push_word_o(push),
    .bus_busy_no(busy_n), .guard_viol_o(viol)
  );

  task automatic cmp(string tag);
    logic [15:0] e_push;
    logic e_viol;
    e_push = ack ? m_stat : 16'h0;
    e_viol = xs && !ack && !ret && (m_stat[1] || m_stat[2]);
    n_chk++;
    if (stat !== m_stat || busy_n !== !m_stat[3] || push !== e_push || viol !== e_viol) begin
      n_bad++;
      $display("FAIL %s: stat=%h busy_n=%b push=%h viol=%b exp stat=%h busy_n=%b push=%h viol=%b",
               tag, stat, busy_n, push, viol, m_stat, !m_stat[3], e_push, e_viol);
    end
  endtask

  // apply inputs at negedge, check, advance model and clock
  task automatic cyc(input logic s, input logic e, input logic a, input logic r,
                     input logic [15:0] rword, input logic w, input logic [15:0] wword,
                     input string tag);
    logic [15:0] n;
    xs = s; xe = e; ack = a; ret = r; rw = rword; we = w; ww = wword;
    #1;
    cmp(tag);
    n = m_stat;
    if (a) n = m_stat & ~CLRM;
    else if (r) n = rword & IMPL;
    else begin
      if (w) begin
        n = wword & IMPL;
        n[3] = m_stat[3];
      end
      if (s) n[3] = 1'b1;
      else if (e) n[3] = 1'b0;
      else if (w && m_stat[3]) n[3] = wword[3];
    end
    m_stat = n;
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 16'h0, 0, 16'h0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    #1; cmp("R1 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    idle("R1 after release");
    // R8: write sets flags, busy field ignored while idle, reserved dropped
    cyc(0, 0, 0, 0, 16'h0, 1, 16'hFF7F, "R8 write");
    idle("R8 result");
    // R2/R3: start then end
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0070, "R8 clear guards");
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, "R2 start");
    idle("R3 busy pin low");
    // R9: write clears busy while busy
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0070, "R9 write busy 0");
    idle("R9 result");
    cyc(1, 1, 0, 0, 16'h0, 0, 16'h0, "R2 start wins end");
    cyc(0, 1, 0, 0, 16'h0, 0, 16'h0, "R2 end");
    idle("R2 idle");
    // R10: guard flags
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0002, "R10 set guard a");
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, "R10 start with guard");
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h0004, "R10 write guard b");
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, "R10 start guard b");
    cyc(0, 1, 0, 0, 16'h0, 1, 16'h0000, "R10 clear");
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, "R10 start clean");
    // R4/R5: ack with all flags set
    cyc(0, 0, 0, 0, 16'h0, 1, 16'h007F, "R9 all flags");
    cyc(0, 0, 1, 0, 16'h0, 0, 16'h0, "R5 push on ack");
    idle("R4 after ack");
    // R6: reti restores, reserved dropped
    cyc(0, 0, 0, 1, 16'hA5FF, 0, 16'h0, "R6 reti");
    idle("R6 result");
    cyc(0, 0, 0, 1, 16'h0031, 0, 16'h0, "R6 reti busy clear");
    // R7: ack beats start, reti, write
    cyc(1, 0, 1, 0, 16'h0, 0, 16'h0, "R7 ack vs start");
    cyc(0, 0, 1, 1, 16'h007F, 1, 16'h007F, "R7 ack vs reti");
    idle("R7 result");
    // R11: reti beats start and write
    cyc(1, 0, 0, 1, 16'h0020, 1, 16'h004F, "R11 reti vs start");
    idle("R11 result");
    cyc(1, 0, 0, 0, 16'h0, 0, 16'h0, "R11 start");
    cyc(0, 1, 0, 1, 16'h000C, 0, 16'h0, "R11 reti vs end");
    idle("R11 busy kept");
    // R3: pseudo-random strobes
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] & lfsr[5], lfsr[1] & lfsr[6], lfsr[2] & lfsr[7] & lfsr[9],
          lfsr[3] & lfsr[8], {lfsr[7:0], lfsr[15:8]}, lfsr[4], lfsr ^ 16'h5A3C,
          "R3 random");
    end
    rst_ni = 1'b0;
    m_stat = '0;
    #1; cmp("R1 reapplied");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule